// File: doc/BRIEF.md
# Test-Port Noise Guard

This block runs in the system clock domain and watches a test access port that should sit in its reset state whenever no debugger is attached. Noise on the test clock and mode pins can walk that port out of reset, and from there it can drift towards an instruction that takes over the pins. The guard brings the port's one-hot state vector and its debugger-present flag across to the system clock through a two-flop synchronizer. It accepts a sample only when two successive samples agree. When no debugger is present and the port has left its reset state, it drives a reset pulse that returns the port to reset before any instruction can be committed.

The mildest case it catches is the step from the reset state to the run-idle state. That step does nothing to the system by itself, but the guard acts on it, and on every other state too. Each pulse is recorded in a saturating event counter and a sticky flag that is cleared by writing one. A 32-bit read-only status word shows the accepted state and the debugger flag. An enable input switches the whole guard off.

Top module: `tap_guard`

## Requirements
- R1: `statusWord` holds the accepted debugger flag in bit 31 and the accepted 16-bit one-hot state in bits 15:0. Bits 30:16 always read zero. The reset-state code is 0x0001 and the run-idle code is 0x0002.
- R2: After power-on reset, `statusWord`, `eventCount`, `stickyFlag` and `tapReset` are all zero.
- R3: While the accepted state is 0x0001 with the debugger flag low, `tapReset` stays low.
- R4: If the state input changes from 0x0001 to 0x0002 with the debugger flag low, `tapReset` rises after the fourth rising clock edge following the edge that first samples the new value.
- R5: A pulse stays high for `pulseLen` clock cycles, and a value of 0 gives one cycle. The port is normally tied to 4.
- R6: Any accepted state that is nonzero and not 0x0001 starts a pulse when the debugger flag is low. An all-zero vector never starts one.
- R7: `eventCount` goes up by one for each pulse started and holds at 255.
- R8: `stickyFlag` is set when a pulse starts and cleared by a cycle with `clrSticky` high. If both happen in the same cycle, the set wins.
- R9: While the accepted debugger flag is high, no pulse starts, whatever the state.
- R10: While `enable` is low, no pulse starts, and a pulse in progress is cut off on the next edge.
- R11: A new input value is accepted only after two consecutive synchronized samples agree, so an input value held for a single clock is never shown and never starts a pulse.
- R12: No new pulse starts while one is running or during the 4 blanking cycles that follow it. A fault that persists restarts pulses every `pulseLen`+5 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| enable | input | 1 | Guard enable |
| pulseLen | input | 4 | Reset pulse length in clocks (0 gives 1) |
| clrSticky | input | 1 | Write-one-to-clear strobe for the sticky flag |
| tapStateAsync | input | 16 | One-hot test-port state, from the test clock domain |
| dbgConnAsync | input | 1 | Debugger-present flag, asynchronous |
| tapReset | output | 1 | Active-high reset request to the test port |
| statusWord | output | 32 | Read-only status word |
| eventCount | output | 8 | Saturating count of reset pulses |
| stickyFlag | output | 1 | Set by any reset pulse |

## Verification
If the filter is wrong, the status word shows a glitch value or lags the input. That is visible three to four edges after the input changes. A wrong trigger condition or pulse timer shows up as `tapReset` rising at the wrong edge, staying high for the wrong number of cycles, or restarting within the blanking window. It also appears one cycle later as a counter value off by one. The bench runs a behavioural model in parallel and compares every output at every clock. A wrong internal state is therefore reported on the first cycle where it reaches a port.

// File: rtl/tap_guard_pkg.sv
package tap_guard_pkg;
  // Strobes the control side hands to the datapath each cycle.
  typedef struct packed {
    logic fire;       // a reset pulse starts this cycle
    logic clrSticky;  // clear request for the sticky flag
  } guardStrobe_t;
endpackage

// File: rtl/tap_guard_datapath.sv
module tap_guard_datapath
  import tap_guard_pkg::*;
#(
  parameter int STATE_W     = 16,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] tapStateAsync,
  input  logic               dbgConnAsync,
  input  guardStrobe_t       strobes,
  output logic [STATE_W-1:0] accState,
  output logic               accDbg,
  output logic [31:0]        statusWord,
  output logic [CNT_W-1:0]   eventCount,
  output logic               stickyFlag
);
  localparam int VEC_W = STATE_W + 1;
  localparam int LAST  = SYNC_STAGES - 1;
  localparam int PAD_W = 31 - STATE_W;

  logic [VEC_W-1:0] syncQ [SYNC_STAGES];
  logic [VEC_W-1:0] prevQ;
  logic [VEC_W-1:0] accVec;
  logic [VEC_W-1:0] lastSync;

  assign lastSync = syncQ[LAST];

  // Synchronizer chain followed by a two-sample agreement filter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
      prevQ  <= '0;
      accVec <= '0;
    end else begin
      syncQ[0] <= {dbgConnAsync, tapStateAsync};
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      prevQ <= lastSync;
      if (lastSync == prevQ) accVec <= lastSync;
    end
  end

  assign accDbg     = accVec[STATE_W];
  assign accState   = accVec[STATE_W-1:0];
  assign statusWord = {accDbg, {PAD_W{1'b0}}, accState};

  // Event counter and sticky flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eventCount <= '0;
      stickyFlag <= 1'b0;
    end else begin
      if (strobes.fire && eventCount != {CNT_W{1'b1}}) eventCount <= eventCount + 1'b1;
      if (strobes.fire)           stickyFlag <= 1'b1;
      else if (strobes.clrSticky) stickyFlag <= 1'b0;
    end
  end

  p_accept_match_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(accVec) |-> $past(lastSync == prevQ));
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fire && eventCount != {CNT_W{1'b1}}) |=> eventCount == $past(eventCount) + 1'b1);
  p_count_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
    eventCount == {CNT_W{1'b1}} |=> eventCount == {CNT_W{1'b1}});
  p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fire |=> stickyFlag);
endmodule

// File: rtl/tap_guard_ctrl.sv
module tap_guard_ctrl
  import tap_guard_pkg::*;
#(
  parameter int STATE_W = 16,
  parameter int PLEN_W  = 4,
  parameter int BLANK   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [PLEN_W-1:0]  pulseLen,
  input  logic               clrSticky,
  input  logic [STATE_W-1:0] accState,
  input  logic               accDbg,
  output guardStrobe_t       strobes,
  output logic               tapReset
);
  localparam int BUSY_W = PLEN_W + 3;
  localparam logic [STATE_W-1:0] RESET_CODE = STATE_W'(1);

  logic [BUSY_W-1:0] busy;
  logic [BUSY_W-1:0] effLen;
  logic              fault;
  logic              fire;

  assign effLen = (pulseLen == '0) ? BUSY_W'(1) : BUSY_W'(pulseLen);
  assign fault  = !accDbg && accState != '0 && accState != RESET_CODE;
  assign fire   = enable && busy == '0 && fault;

  // One counter covers both the pulse and the blanking tail after it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             busy <= '0;
    else if (!enable)      busy <= '0;
    else if (fire)         busy <= effLen + BUSY_W'(BLANK);
    else if (busy != '0)   busy <= busy - 1'b1;
  end

  assign tapReset          = busy > BUSY_W'(BLANK);
  assign strobes.fire      = fire;
  assign strobes.clrSticky = clrSticky;

  p_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tapReset) |-> $past(enable && !accDbg && accState != '0 && accState != RESET_CODE));
  p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !tapReset);
  p_no_retrigger_r12: assert property (@(posedge clk) disable iff (!rstN)
    (enable && busy != '0) |=> busy == $past(busy) - 1'b1);
endmodule

// File: rtl/tap_guard.sv
module tap_guard
  import tap_guard_pkg::*;
#(
  parameter int STATE_W     = 16,
  parameter int PLEN_W      = 4,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [PLEN_W-1:0]  pulseLen,
  input  logic               clrSticky,
  input  logic [STATE_W-1:0] tapStateAsync,
  input  logic               dbgConnAsync,
  output logic               tapReset,
  output logic [31:0]        statusWord,
  output logic [CNT_W-1:0]   eventCount,
  output logic               stickyFlag
);
  // Blanking covers the synchronizer and filter latency after a pulse.
  localparam int BLANK = SYNC_STAGES + 2;

  guardStrobe_t       strobes;
  logic [STATE_W-1:0] accState;
  logic               accDbg;

  tap_guard_datapath #(.STATE_W(STATE_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .tapStateAsync(tapStateAsync), .dbgConnAsync(dbgConnAsync),
    .strobes(strobes), .accState(accState), .accDbg(accDbg),
    .statusWord(statusWord), .eventCount(eventCount), .stickyFlag(stickyFlag));

  tap_guard_ctrl #(.STATE_W(STATE_W), .PLEN_W(PLEN_W), .BLANK(BLANK)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .pulseLen(pulseLen), .clrSticky(clrSticky),
    .accState(accState), .accDbg(accDbg), .strobes(strobes), .tapReset(tapReset));
endmodule

// File: tb/tap_guard_test.sv
module tap_guard_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b1;
  logic [3:0]  pulseLen = 4'd4;
  logic        clrSticky = 1'b0;
  logic [15:0] tapIn = 16'h0001;
  logic        dbgIn = 1'b0;
  logic        tapReset;
  logic [31:0] statusWord;
  logic [7:0]  eventCount;
  logic        stickyFlag;

  int checks = 0;
  int errors = 0;
  bit snapBack = 1'b1;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tap_guard uut (
    .clk(clk), .rstN(rstN), .enable(enable), .pulseLen(pulseLen), .clrSticky(clrSticky),
    .tapStateAsync(tapIn), .dbgConnAsync(dbgIn), .tapReset(tapReset),
    .statusWord(statusWord), .eventCount(eventCount), .stickyFlag(stickyFlag));

  // Behavioural reference: a history of raw samples, the accepted value,
  // a pulse-plus-blanking countdown, the counter and the flag.
  logic [16:0] hist[$];
  logic [16:0] mAcc;
  int          mBusy, mCnt, mEff;
  bit          mSticky, mFire;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist = '{17'd0, 17'd0, 17'd0};
      mAcc = '0; mBusy = 0; mCnt = 0; mSticky = 1'b0;
    end else begin
      mEff  = (pulseLen == 0) ? 1 : int'(pulseLen);
      mFire = enable && mBusy == 0 && !mAcc[16] && mAcc[15:0] != 16'h0 && mAcc[15:0] != 16'h1;
      if (!enable)      mBusy = 0;
      else if (mFire)   mBusy = mEff + 4;
      else if (mBusy>0) mBusy = mBusy - 1;
      if (mFire) begin
        if (mCnt < 255) mCnt = mCnt + 1;
        mSticky = 1'b1;
      end else if (clrSticky) mSticky = 1'b0;
      if (hist[1] == hist[2]) mAcc = hist[1];
      hist.push_front({dbgIn, tapIn});
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R1 status word", statusWord, {mAcc[16], 15'd0, mAcc[15:0]});
      chk("R5 reset pulse", tapReset, (mBusy > 4) ? 1 : 0);
      chk("R7 event count", eventCount, mCnt);
      chk("R8 sticky flag", stickyFlag, mSticky);
    end
  end

  // The port under guard returns to its reset state while tapReset is high.
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tapReset && snapBack) tapIn = 16'h0001;
    end
  endtask

  task automatic pulseWidth(output int w);
    w = 0;
    while (tapReset && w < 100) begin tick(1); w++; end
  endtask

  task automatic finish_run;
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired (all requirements)");
    finish_run();
  end

  initial begin
    int w, gap;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R2: reset values
    chk("R2 status", statusWord, 0);
    chk("R2 tapReset", tapReset, 0);
    chk("R2 count", eventCount, 0);
    chk("R2 sticky", stickyFlag, 0);

    // R3: quiet port in reset state with no debugger
    tick(20);
    chk("R3 no pulse", eventCount, 0);
    chk("R1 reset code shown", statusWord, 32'h0000_0001);

    // R4/R5: reset state to run-idle
    tapIn = 16'h0002;
    tick(4);
    chk("R4 not yet", tapReset, 0);
    tick(1);
    chk("R4 rise", tapReset, 1);
    pulseWidth(w);
    chk("R5 width 4", w, 4);
    tick(10);
    chk("R7 one event", eventCount, 1);
    chk("R8 sticky set", stickyFlag, 1);
    chk("R1 back to reset code", statusWord, 32'h0000_0001);
    clrSticky = 1'b1; tick(1); clrSticky = 1'b0;
    chk("R8 sticky cleared", stickyFlag, 0);

    // R6: another state, then the all-zero vector
    tapIn = 16'h0010;
    tick(5);
    chk("R6 other state", tapReset, 1);
    pulseWidth(w);
    tick(10);
    tapIn = 16'h0000;
    tick(15);
    chk("R6 zero vector", eventCount, 2);
    tapIn = 16'h0001; tick(5);

    // R9: debugger attached
    dbgIn = 1'b1; tick(5);
    tapIn = 16'h0002; tick(15);
    chk("R9 suppressed", eventCount, 2);
    chk("R1 debugger bit", statusWord, 32'h8000_0002);
    tapIn = 16'h0001; tick(5);
    dbgIn = 1'b0; tick(5);

    // R10: guard disabled
    enable = 1'b0;
    tapIn = 16'h0002; tick(15);
    chk("R10 disabled", tapReset, 0);
    chk("R10 no event", eventCount, 2);
    tapIn = 16'h0001; tick(5);
    enable = 1'b1; tick(2);

    // R11: single-clock glitch
    tapIn = 16'h0002; tick(1);
    tapIn = 16'h0001; tick(15);
    chk("R11 glitch ignored", eventCount, 2);
    chk("R11 glitch not shown", statusWord, 32'h0000_0001);

    // R5: length 0 and 7
    pulseLen = 4'd0;
    tapIn = 16'h0002; tick(5);
    pulseWidth(w);
    chk("R5 width for 0", w, 1);
    tick(10);
    pulseLen = 4'd7;
    tapIn = 16'h0002; tick(5);
    pulseWidth(w);
    chk("R5 width 7", w, 7);
    tick(10);
    pulseLen = 4'd4;

    // R12: persistent fault retriggers after pulse plus blanking
    snapBack = 1'b0;
    tapIn = 16'h0002;
    w = 0;
    while (!tapReset && w < 50) begin tick(1); w++; end
    gap = 0;
    while (tapReset && gap < 50) begin tick(1); gap++; end
    while (!tapReset && gap < 50) begin tick(1); gap++; end
    chk("R12 restart period", gap, 9);

    // R7: saturation
    pulseLen = 4'd1;
    w = 0;
    while (eventCount != 8'd255 && w < 5000) begin tick(1); w++; end
    tick(50);
    chk("R7 saturated", eventCount, 255);
    snapBack = 1'b1;
    tapIn = 16'h0001;
    tick(20);
    finish_run();
  end
endmodule